// File: doc/BRIEF.md
# Interrupt Controller Access-Mode Gate

This block holds the operating mode of a local interrupt controller and decides, for each register access, what happens to it. An access arrives on one request channel and is tagged as coming from either the model-specific-register (MSR) style interface or the memory-mapped (MMIO) interface. Based on the two mode bits (enable, extended) and the interface used, the access is forwarded to an internal register file, refused with a general-protection fault, or answered as if the controller were globally disabled (reads give zero, writes vanish).

A separate combinational screen examines the low 32 bits of entries in the MSR lists used on virtualization transitions. An entry whose masked value hits the controller's MSR window is flagged; on the entry path this becomes an entry-failure indication, on the exit path an abort indication.

Top module: `irqc_access_gate`

## Requirements
- R1: Synchronous reset puts the mode at legacy (mode_en=1, mode_ext=0); after reset release req_ready stays low for 2^IDX_W cycles (one per register slot) and then goes high.
- R2: A mode write with {enable,extended} equal to 00 (disabled), 10 (legacy) or 11 (extended) is visible on mode_en/mode_ext in the cycle after it is accepted, with mode_set_fault low.
- R3: A mode write of enable=0, extended=1 raises mode_set_fault for one cycle one cycle later and leaves the mode unchanged.
- R4: In extended mode, an MSR access with address 0x800..0xBFF is forwarded to the register file at index addr[IDX_W-1:0]; a read returns the stored word with resp_fault low.
- R5: An MSR access while not in extended mode returns resp_fault=1 and resp_rdata=0 and changes no register.
- R6: An MSR access with an address outside 0x800..0xBFF faults in every mode.
- R7: In legacy mode, an MMIO access is forwarded to the register file at index addr[IDX_W+3:4] (16-byte slot spacing; the low four address bits are ignored).
- R8: In extended or disabled mode, an MMIO read returns zero and an MMIO write is dropped, both without fault.
- R9: Every accepted access produces exactly one resp_done pulse in the next cycle; accesses complete in issue order, so a read accepted right after a write to the same slot returns the new value.
- R10: An access accepted in the same cycle as a mode write is judged against the mode held before that write.
- R11: A transition-list entry is flagged when (entry AND 0xFFFFF800) equals 0x00000800, and never while tl_valid is low.
- R12: A flagged entry drives tl_entry_fail when tl_is_exit=0 and tl_abort when tl_is_exit=1, never both.
- R13: After reset every register slot reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_set_valid | input | 1 | Mode write strobe |
| mode_set_en | input | 1 | Requested enable bit |
| mode_set_ext | input | 1 | Requested extended bit |
| mode_en | output | 1 | Current enable bit |
| mode_ext | output | 1 | Current extended bit |
| mode_set_fault | output | 1 | Pulse: illegal mode write rejected |
| req_valid | input | 1 | Access request valid |
| req_ready | output | 1 | Access can be accepted |
| req_is_msr | input | 1 | 1 = MSR interface, 0 = MMIO interface |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | MSR number or MMIO byte offset |
| req_wdata | input | DATA_W | Write data |
| resp_done | output | 1 | One-cycle completion pulse |
| resp_fault | output | 1 | General-protection fault, valid with resp_done |
| resp_rdata | output | DATA_W | Read data, valid with resp_done |
| tl_valid | input | 1 | Transition-list entry present |
| tl_is_exit | input | 1 | 1 = exit path, 0 = entry path |
| tl_entry | input | 32 | Low 32 bits of the list entry |
| tl_entry_fail | output | 1 | Entry-path failure |
| tl_abort | output | 1 | Exit-path abort |

## Verification
A mode write and a register access can be accepted on the same clock edge, and the outcome of the access depends on which mode it is judged against. The bench issues both in one cycle in each direction (extended to legacy with an MSR read, legacy to extended with an MMIO write) and expects the old mode's behaviour, then confirms through a follow-up access in the new mode that the first access took effect where the old mode sends it.

// File: rtl/irqc_gate_pkg.sv
package irqc_gate_pkg;

  // Mode bits packed as {enable, extended}
  typedef enum logic [1:0] {
    MODE_OFF    = 2'b00,
    MODE_BAD    = 2'b01,
    MODE_LEGACY = 2'b10,
    MODE_EXT    = 2'b11
  } irqc_mode_e;

  // Outcome of an access decision
  typedef enum logic [1:0] {
    ACT_FWD   = 2'd0,
    ACT_FAULT = 2'd1,
    ACT_QUIET = 2'd2
  } irqc_act_e;

endpackage

// File: rtl/irqc_mode_reg.sv
module irqc_mode_reg
  import irqc_gate_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       set_valid,
  input  logic       set_en,
  input  logic       set_ext,
  output irqc_mode_e mode,
  output logic       set_fault
);

  logic [1:0] req_bits;
  logic       req_bad;

  assign req_bits = {set_en, set_ext};
  assign req_bad  = (req_bits == MODE_BAD);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode      <= MODE_LEGACY;
      set_fault <= 1'b0;
    end else begin
      set_fault <= set_valid && req_bad;
      if (set_valid && !req_bad) begin
        mode <= irqc_mode_e'(req_bits);
      end
    end
  end

endmodule

// File: rtl/irqc_access_decode.sv
module irqc_access_decode
  import irqc_gate_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int IDX_W     = 6,
  parameter int STRIDE_LG = 4,
  parameter logic [ADDR_W-1:0] MSR_LO = 'h800,
  parameter logic [ADDR_W-1:0] MSR_HI = 'hBFF
) (
  input  logic              is_msr,
  input  logic [ADDR_W-1:0] addr,
  input  irqc_mode_e        mode,
  output irqc_act_e         act,
  output logic [IDX_W-1:0]  idx
);

  logic msr_in_window;
  logic [IDX_W-1:0] msr_idx;
  logic [IDX_W-1:0] mmio_idx;

  assign msr_in_window = (addr >= MSR_LO) && (addr <= MSR_HI);
  assign msr_idx       = addr[IDX_W-1:0];

  generate
    if (STRIDE_LG == 0) begin : g_mmio_packed
      assign mmio_idx = addr[IDX_W-1:0];
    end else begin : g_mmio_strided
      assign mmio_idx = addr[IDX_W+STRIDE_LG-1:STRIDE_LG];
    end
  endgenerate

  always_comb begin
    if (is_msr) begin
      idx = msr_idx;
      act = (msr_in_window && mode == MODE_EXT) ? ACT_FWD : ACT_FAULT;
    end else begin
      idx = mmio_idx;
      act = (mode == MODE_LEGACY) ? ACT_FWD : ACT_QUIET;
    end
  end

endmodule

// File: rtl/irqc_regfile.sv
module irqc_regfile #(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic              busy
);

  localparam int DEPTH = 1 << IDX_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [IDX_W-1:0]  sweep_idx;
  logic              mem_we;
  logic [IDX_W-1:0]  mem_wa;
  logic [DATA_W-1:0] mem_wd;

  // Post-reset sweep writes zero into every slot, one per cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b1;
      sweep_idx <= '0;
    end else if (busy) begin
      sweep_idx <= sweep_idx + 1'b1;
      if (sweep_idx == {IDX_W{1'b1}}) begin
        busy <= 1'b0;
      end
    end
  end

  assign mem_we = busy || wr_en;
  assign mem_wa = busy ? sweep_idx : wr_idx;
  assign mem_wd = busy ? '0 : wr_data;

  // Single-port style storage without reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (mem_we) begin
      mem[mem_wa] <= mem_wd;
    end
    rd_data <= mem[rd_idx];
  end

endmodule

// File: rtl/irqc_xlist_screen.sv
module irqc_xlist_screen #(
  parameter logic [31:0] MASK  = 32'hFFFF_F800,
  parameter logic [31:0] MATCH = 32'h0000_0800
) (
  input  logic        valid,
  input  logic        is_exit,
  input  logic [31:0] entry,
  output logic        entry_fail,
  output logic        abort
);

  logic hit;

  assign hit        = valid && ((entry & MASK) == MATCH);
  assign entry_fail = hit && !is_exit;
  assign abort      = hit && is_exit;

endmodule

// File: rtl/irqc_access_gate.sv
module irqc_access_gate
  import irqc_gate_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int IDX_W     = 6,
  parameter int STRIDE_LG = 4,
  parameter logic [ADDR_W-1:0] MSR_LO = 'h800,
  parameter logic [ADDR_W-1:0] MSR_HI = 'hBFF,
  parameter logic [31:0] TL_MASK  = 32'hFFFF_F800,
  parameter logic [31:0] TL_MATCH = 32'h0000_0800
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_set_valid,
  input  logic              mode_set_en,
  input  logic              mode_set_ext,
  output logic              mode_en,
  output logic              mode_ext,
  output logic              mode_set_fault,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_is_msr,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              resp_done,
  output logic              resp_fault,
  output logic [DATA_W-1:0] resp_rdata,
  input  logic              tl_valid,
  input  logic              tl_is_exit,
  input  logic [31:0]       tl_entry,
  output logic              tl_entry_fail,
  output logic              tl_abort
);

  irqc_mode_e        cur_mode;
  irqc_act_e         act;
  logic [IDX_W-1:0]  slot;
  logic              rf_busy;
  logic [DATA_W-1:0] rf_rdata;
  logic              take;
  logic              rf_we;
  logic              done_q;
  logic              fault_q;
  logic              rsel_q;

  irqc_mode_reg u_mode (
    .clk       (clk),
    .rst       (rst),
    .set_valid (mode_set_valid),
    .set_en    (mode_set_en),
    .set_ext   (mode_set_ext),
    .mode      (cur_mode),
    .set_fault (mode_set_fault)
  );

  assign mode_en  = cur_mode[1];
  assign mode_ext = cur_mode[0];

  irqc_access_decode #(
    .ADDR_W    (ADDR_W),
    .IDX_W     (IDX_W),
    .STRIDE_LG (STRIDE_LG),
    .MSR_LO    (MSR_LO),
    .MSR_HI    (MSR_HI)
  ) u_dec (
    .is_msr (req_is_msr),
    .addr   (req_addr),
    .mode   (cur_mode),
    .act    (act),
    .idx    (slot)
  );

  assign req_ready = !rf_busy;
  assign take      = req_valid && req_ready;
  assign rf_we     = take && req_write && (act == ACT_FWD);

  irqc_regfile #(
    .DATA_W (DATA_W),
    .IDX_W  (IDX_W)
  ) u_rf (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (rf_we),
    .wr_idx  (slot),
    .wr_data (req_wdata),
    .rd_idx  (slot),
    .rd_data (rf_rdata),
    .busy    (rf_busy)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      rsel_q  <= 1'b0;
    end else begin
      done_q  <= take;
      fault_q <= take && (act == ACT_FAULT);
      rsel_q  <= take && !req_write && (act == ACT_FWD);
    end
  end

  assign resp_done  = done_q;
  assign resp_fault = fault_q;
  assign resp_rdata = rsel_q ? rf_rdata : '0;

  irqc_xlist_screen #(
    .MASK  (TL_MASK),
    .MATCH (TL_MATCH)
  ) u_xl (
    .valid      (tl_valid),
    .is_exit    (tl_is_exit),
    .entry      (tl_entry),
    .entry_fail (tl_entry_fail),
    .abort      (tl_abort)
  );

endmodule

// File: rtl/irqc_access_gate_chk.sv
module irqc_access_gate_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] MSR_LO = 'h800,
  parameter logic [ADDR_W-1:0] MSR_HI = 'hBFF
) (
  input logic              clk,
  input logic              rst,
  input logic              mode_set_valid,
  input logic              mode_set_en,
  input logic              mode_set_ext,
  input logic              mode_en,
  input logic              mode_ext,
  input logic              mode_set_fault,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_is_msr,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [DATA_W-1:0] req_wdata,
  input logic              resp_done,
  input logic              resp_fault,
  input logic [DATA_W-1:0] resp_rdata,
  input logic              tl_valid,
  input logic              tl_is_exit,
  input logic [31:0]       tl_entry,
  input logic              tl_entry_fail,
  input logic              tl_abort
);

  logic acc;
  assign acc = req_valid && req_ready;

  p_mode_legal_r2: assert property (@(posedge clk) disable iff (rst)
    !(!mode_en && mode_ext));

  p_bad_mode_r3: assert property (@(posedge clk) disable iff (rst)
    (mode_set_valid && !mode_set_en && mode_set_ext)
      |=> (mode_set_fault && $stable({mode_en, mode_ext})));

  p_msr_fault_r5: assert property (@(posedge clk) disable iff (rst)
    (acc && req_is_msr && !(mode_en && mode_ext)) |=> (resp_fault && resp_rdata == '0));

  p_msr_range_r6: assert property (@(posedge clk) disable iff (rst)
    (acc && req_is_msr && (req_addr < MSR_LO || req_addr > MSR_HI)) |=> resp_fault);

  p_mmio_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    (acc && !req_is_msr && !(mode_en && !mode_ext))
      |=> (!resp_fault && resp_rdata == '0));

  p_done_r9: assert property (@(posedge clk) disable iff (rst)
    acc |=> resp_done);

  p_no_stray_done_r9: assert property (@(posedge clk) disable iff (rst)
    !acc |=> !resp_done);

  p_tl_hit_r11: assert property (@(posedge clk) disable iff (rst)
    (tl_valid && tl_entry[31:11] == 21'h1) |-> (tl_entry_fail || tl_abort));

  p_tl_idle_r11: assert property (@(posedge clk) disable iff (rst)
    !tl_valid |-> !(tl_entry_fail || tl_abort));

  p_tl_path_r12: assert property (@(posedge clk) disable iff (rst)
    (!(tl_entry_fail && tl_abort)) && (!tl_abort || tl_is_exit) && (!tl_entry_fail || !tl_is_exit));

endmodule

bind irqc_access_gate irqc_access_gate_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .MSR_LO (MSR_LO),
  .MSR_HI (MSR_HI)
) u_chk (.*);

// File: tb/irqc_access_gate_tb.sv
module irqc_access_gate_tb;

  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int IDX_W  = 6;
  localparam int DEPTH  = 1 << IDX_W;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              mode_set_valid = 1'b0;
  logic              mode_set_en = 1'b0;
  logic              mode_set_ext = 1'b0;
  logic              mode_en, mode_ext, mode_set_fault;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic              req_is_msr = 1'b0;
  logic              req_write = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic              resp_done, resp_fault;
  logic [DATA_W-1:0] resp_rdata;
  logic              tl_valid = 1'b0;
  logic              tl_is_exit = 1'b0;
  logic [31:0]       tl_entry = '0;
  logic              tl_entry_fail, tl_abort;

  always #5 clk = ~clk;

  irqc_access_gate u_dut (.*);

  typedef struct {
    logic [DATA_W-1:0] rdata;
    logic              fault;
    string             tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_run  = 0;
  int   n_fail = 0;
  bit   ended  = 1'b0;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  // Monitor: pops the scoreboard on every completion pulse
  always @(negedge clk) begin
    if (!rst && resp_done) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R9 unexpected done", 64'd1, 64'd0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(resp_fault == e.fault, {e.tag, " fault"}, 64'(resp_fault), 64'(e.fault));
        check(resp_rdata == e.rdata, {e.tag, " rdata"}, 64'(resp_rdata), 64'(e.rdata));
      end
    end
  end

  // Driver: one access, optionally with a mode write in the same cycle
  task automatic acc(input bit msr, input bit wr, input logic [31:0] addr, input logic [31:0] data,
                     input logic [31:0] exp_rd, input bit exp_f, input string tag,
                     input bit mw = 1'b0, input bit men = 1'b0, input bit mext = 1'b0);
    exp_t e;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_is_msr = msr; req_write = wr; req_addr = addr; req_wdata = data;
    mode_set_valid = mw; mode_set_en = men; mode_set_ext = mext;
    e.rdata = exp_rd; e.fault = exp_f; e.tag = tag;
    exp_q.push_back(e);
    @(posedge clk);
    #1;
    req_valid = 1'b0; mode_set_valid = 1'b0;
  endtask

  task automatic set_mode(input bit men, input bit mext, input bit exp_f,
                          input bit exp_en, input bit exp_ext, input string tag);
    @(negedge clk);
    mode_set_valid = 1'b1; mode_set_en = men; mode_set_ext = mext;
    @(posedge clk);
    #1;
    mode_set_valid = 1'b0;
    @(negedge clk);
    check(mode_set_fault == exp_f, {tag, " mode fault"}, 64'(mode_set_fault), 64'(exp_f));
    check({mode_en, mode_ext} == {exp_en, exp_ext}, {tag, " mode"},
          64'({mode_en, mode_ext}), 64'({exp_en, exp_ext}));
  endtask

  task automatic tl_chk(input logic [31:0] ent, input bit v, input bit ex,
                        input bit exp_fail, input bit exp_abort, input string tag);
    @(negedge clk);
    tl_valid = v; tl_is_exit = ex; tl_entry = ent;
    #1;
    check({tl_entry_fail, tl_abort} == {exp_fail, exp_abort}, tag,
          64'({tl_entry_fail, tl_abort}), 64'({exp_fail, exp_abort}));
  endtask

  task automatic drain();
    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R9 all responses seen", 64'(exp_q.size()), 64'd0);
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    check(1'b0, "watchdog expired", 64'd1, 64'd0);
    finish_run();
  end

  initial begin
    int lowc;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check({mode_en, mode_ext} == 2'b10, "R1 reset mode", 64'({mode_en, mode_ext}), 64'h2);
    check(req_ready == 1'b0, "R1 ready low after reset", 64'(req_ready), 64'd0);
    lowc = 0;
    while (!req_ready && lowc < DEPTH + 8) begin
      @(negedge clk);
      lowc++;
    end
    check(lowc >= DEPTH - 1 && lowc <= DEPTH + 1, "R1 sweep length", 64'(lowc), 64'(DEPTH));

    // R13: cleared slots
    acc(1'b0, 1'b0, 32'h000, '0, 32'h0, 1'b0, "R13 slot0 zero");
    acc(1'b0, 1'b0, 32'h3F0, '0, 32'h0, 1'b0, "R13 last slot zero");

    // R7: legacy MMIO forwarding, low offset bits ignored
    acc(1'b0, 1'b1, 32'h020, 32'hA5A5_0002, 32'h0, 1'b0, "R7 mmio write");
    acc(1'b0, 1'b0, 32'h02C, '0, 32'hA5A5_0002, 1'b0, "R7 mmio read");

    // R5: MSR in legacy faults, register untouched
    acc(1'b1, 1'b1, 32'h802, 32'hDEAD_BEEF, 32'h0, 1'b1, "R5 msr write legacy");
    acc(1'b1, 1'b0, 32'h802, '0, 32'h0, 1'b1, "R5 msr read legacy");
    acc(1'b0, 1'b0, 32'h020, '0, 32'hA5A5_0002, 1'b0, "R5 slot unchanged");

    // R2: to extended
    set_mode(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, "R2 to ext");

    // R6: out of window MSR
    acc(1'b1, 1'b0, 32'h7FF, '0, 32'h0, 1'b1, "R6 below window");
    acc(1'b1, 1'b1, 32'hC00, 32'h1, 32'h0, 1'b1, "R6 above window");

    // R4 and R9: MSR access in extended, back-to-back ordering
    acc(1'b1, 1'b0, 32'h802, '0, 32'hA5A5_0002, 1'b0, "R4 msr read shared slot");
    acc(1'b1, 1'b1, 32'h805, 32'hC0DE_0005, 32'h0, 1'b0, "R4 msr write");
    acc(1'b1, 1'b0, 32'h805, '0, 32'hC0DE_0005, 1'b0, "R9 read after write");
    acc(1'b1, 1'b0, 32'hBC5, '0, 32'hC0DE_0005, 1'b0, "R4 top of window aliases");

    // R8: MMIO quiet in extended
    acc(1'b0, 1'b0, 32'h020, '0, 32'h0, 1'b0, "R8 mmio read ext");
    acc(1'b0, 1'b1, 32'h050, 32'hFFFF_FFFF, 32'h0, 1'b0, "R8 mmio write ext");
    acc(1'b1, 1'b0, 32'h805, '0, 32'hC0DE_0005, 1'b0, "R8 write dropped");

    // R3: illegal mode
    set_mode(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, "R3 illegal");

    // R10: same-cycle mode change uses the old mode
    acc(1'b1, 1'b0, 32'h805, '0, 32'hC0DE_0005, 1'b0, "R10 msr with ext->legacy", 1'b1, 1'b1, 1'b0);
    @(negedge clk);
    check({mode_en, mode_ext} == 2'b10, "R10 mode now legacy", 64'({mode_en, mode_ext}), 64'h2);
    acc(1'b0, 1'b0, 32'h050, '0, 32'hC0DE_0005, 1'b0, "R10 legacy mmio sees slot5");
    acc(1'b0, 1'b1, 32'h070, 32'h7777_0007, 32'h0, 1'b0, "R10 mmio write with legacy->ext", 1'b1, 1'b1, 1'b1);
    acc(1'b1, 1'b0, 32'h807, '0, 32'h7777_0007, 1'b0, "R10 ext msr sees slot7");

    // R2/R5/R8: disabled mode
    set_mode(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R2 to off");
    acc(1'b1, 1'b0, 32'h807, '0, 32'h0, 1'b1, "R5 msr off");
    acc(1'b0, 1'b0, 32'h070, '0, 32'h0, 1'b0, "R8 mmio off");
    drain();

    // R11/R12: transition-list screen
    tl_chk(32'h0000_0800, 1'b1, 1'b1, 1'b0, 1'b1, "R12 exit abort");
    tl_chk(32'h0000_08FF, 1'b1, 1'b0, 1'b1, 1'b0, "R12 entry fail");
    tl_chk(32'h0000_0FFF, 1'b1, 1'b0, 1'b1, 1'b0, "R11 masked top");
    tl_chk(32'h0000_07FF, 1'b1, 1'b0, 1'b0, 1'b0, "R11 below");
    tl_chk(32'h0000_1800, 1'b1, 1'b1, 1'b0, 1'b0, "R11 high bit set");
    tl_chk(32'h0000_0800, 1'b0, 1'b1, 1'b0, 1'b0, "R11 not valid");
    tl_valid = 1'b0;

    finish_run();
  end

endmodule